// File: doc/BRIEF.md
# Odd/Even Cell Balancing Scheduler

This block decides, every clock cycle, which of the balancing switches across five series-connected cells are driven. Each cell's voltage arrives as a millivolt code. A cell becomes a balancing candidate when its voltage climbs past an upper threshold. That threshold is a fixed start voltage plus a programmable gap. The cell stays a candidate until its voltage drops back to the start voltage. A cell flagged over-voltage follows a separate rule. It keeps balancing until its voltage falls below the higher of two stop levels, one set by a programmable gap and one by a fixed hysteresis, both measured below the over-voltage limit.

Adjacent cells share circuitry, so odd cells (1, 3, 5) and even cells (2, 4) are never driven together. When both groups have work, the block alternates between them in slots of a fixed number of clock cycles. When only one group has work, that group is served at once. All outputs drop while a voltage measurement is in progress. The active-low enable input is passed unchanged to the device above in the stack.

Top module: `cell_bal_sched`

## Requirements
- R1: After reset all gate outputs are 0, and the first slot served when both groups need balancing is the odd group.
- R2: A cell latched by the voltage rule drives its gate only while bal_en_ni is 0, stack_fault_i is 0, dsg_fault_i is 0 and charging_i is 1.
- R3: The voltage rule latches a cell when its code is strictly greater than START_MV + (cfg_i[1:0]+1)*STEP_MV. It releases the cell when the code is at or below START_MV. Between the two levels the cell keeps its state. The latch takes effect on the clock edge that samples the code.
- R4: Gate bits 0, 2 and 4 (odd cells) are never high in the same cycle as bits 1 or 3 (even cells).
- R5: While both groups need balancing, each group is served for exactly TBAL_CYC consecutive cycles and then the other group is served.
- R6: When only one group needs balancing, its gates follow its needs in the same cycle, with no wait for a slot.
- R7: While meas_i is 1, all gate outputs are 0, whatever the other inputs are.
- R8: A cell whose ov_flag_i bit was 1 is balanced while bal_en_ni is 0 and dsg_fault_i is 0. charging_i and stack_fault_i do not affect it.
- R9: Over-voltage balancing of a cell stops on the edge where its code is below max(VOV_MV - (cfg_i[3:2]+1)*STEP_MV, VOV_MV - OV_HYS_MV), provided its flag is 0.
- R10: cbo_no always equals bal_en_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_mv_i | input | N_CELL*MV_W | Cell voltage codes in mV, cell 1 in the lowest field |
| ov_flag_i | input | N_CELL | Per-cell over-voltage flags |
| bal_en_ni | input | 1 | Balancing enable, active low |
| stack_fault_i | input | 1 | A fault is present somewhere in the stack |
| dsg_fault_i | input | 1 | A discharge fault is present somewhere in the stack |
| charging_i | input | 1 | Pack is charging |
| meas_i | input | 1 | Measurement window in progress |
| cfg_i | input | 4 | [1:0] balancing gap code, [3:2] over-voltage stop gap code |
| bal_gate_o | output | N_CELL | Balancing switch drives, bit 0 = cell 1 |
| cbo_no | output | 1 | Enable passed to the next device up, active low |

## Verification
The assertions assume that the voltage codes, flags, fault inputs and configuration change only between clock edges and stay stable around each edge. They also assume that meas_i is a clean level and does not glitch. The stimulus changes all inputs one time unit after a rising edge and samples one unit after that. Voltages are placed exactly on the threshold values and one millivolt on either side of them, so no comparison depends on input timing.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic {PH_ODD = 1'b0, PH_EVEN = 1'b1} phase_e;

  // Odd cells (1,3,5...) sit on even bit indices
  function automatic logic [31:0] odd_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = (i % 2 == 0);
    return m;
  endfunction
endpackage

// File: rtl/cbs_thresh.sv
module cbs_thresh #(
  parameter int MV_W      = 13,
  parameter int START_MV  = 3800,
  parameter int STEP_MV   = 50,
  parameter int VOV_MV    = 4300,
  parameter int OV_HYS_MV = 100
) (
  input  logic [1:0]      win_code_i,
  input  logic [1:0]      ov_code_i,
  output logic [MV_W-1:0] upper_mv_o,
  output logic [MV_W-1:0] ov_stop_mv_o
);
  localparam logic [MV_W-1:0] START  = MV_W'(START_MV);
  localparam logic [MV_W-1:0] HYS_LV = MV_W'(VOV_MV - OV_HYS_MV);
  localparam logic [MV_W-1:0] VOV    = MV_W'(VOV_MV);

  logic [MV_W-1:0] win_gap, ov_gap, gap_lv;

  always_comb begin
    win_gap = MV_W'(STEP_MV) * MV_W'({1'b0, win_code_i} + 3'd1);
    ov_gap  = MV_W'(STEP_MV) * MV_W'({1'b0, ov_code_i} + 3'd1);
    gap_lv  = VOV - ov_gap;
    upper_mv_o   = START + win_gap;
    // stop at whichever level is met first while falling
    ov_stop_mv_o = (gap_lv > HYS_LV) ? gap_lv : HYS_LV;
  end
endmodule

// File: rtl/cbs_cell_track.sv
module cbs_cell_track #(
  parameter int MV_W = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [MV_W-1:0] mv_i,
  input  logic [MV_W-1:0] upper_mv_i,
  input  logic [MV_W-1:0] lower_mv_i,
  input  logic [MV_W-1:0] ov_stop_mv_i,
  input  logic            ov_flag_i,
  output logic            norm_o,
  output logic            ov_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_o <= 1'b0;
      ov_o   <= 1'b0;
    end else begin
      if (mv_i > upper_mv_i)       norm_o <= 1'b1;
      else if (mv_i <= lower_mv_i) norm_o <= 1'b0;
      if (ov_flag_i)               ov_o <= 1'b1;
      else if (mv_i < ov_stop_mv_i) ov_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cbs_slot_arb.sv
module cbs_slot_arb
  import cbs_pkg::*;
#(
  parameter int TBAL_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic odd_need_i,
  input  logic even_need_i,
  output logic sel_odd_o
);
  localparam int CNT_W = $clog2(TBAL_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TBAL_CYC - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             both;

  assign both = odd_need_i & even_need_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ODD;
      cnt_q   <= '0;
    end else if (both) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_ODD) ? PH_EVEN : PH_ODD;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      if (odd_need_i)       phase_q <= PH_ODD;
      else if (even_need_i) phase_q <= PH_EVEN;
    end
  end

  assign sel_odd_o = odd_need_i & (~even_need_i | (phase_q == PH_ODD));
endmodule

// File: rtl/cell_bal_sched.sv
module cell_bal_sched
  import cbs_pkg::*;
#(
  parameter int N_CELL    = 5,
  parameter int MV_W      = 13,
  parameter int START_MV  = 3800,
  parameter int STEP_MV   = 50,
  parameter int VOV_MV    = 4300,
  parameter int OV_HYS_MV = 100,
  parameter int TBAL_CYC  = 1000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CELL*MV_W-1:0] cell_mv_i,
  input  logic [N_CELL-1:0]      ov_flag_i,
  input  logic                   bal_en_ni,
  input  logic                   stack_fault_i,
  input  logic                   dsg_fault_i,
  input  logic                   charging_i,
  input  logic                   meas_i,
  input  logic [3:0]             cfg_i,
  output logic [N_CELL-1:0]      bal_gate_o,
  output logic                   cbo_no
);
  localparam logic [N_CELL-1:0] ODD_M = N_CELL'(odd_mask(N_CELL));
  localparam logic [MV_W-1:0]   LOWER = MV_W'(START_MV);

  logic [MV_W-1:0]   upper_mv, ov_stop_mv;
  logic [N_CELL-1:0] norm_lat, ov_lat, need;
  logic              normal_ok, ov_ok, sel_odd;

  cbs_thresh #(
    .MV_W(MV_W), .START_MV(START_MV), .STEP_MV(STEP_MV),
    .VOV_MV(VOV_MV), .OV_HYS_MV(OV_HYS_MV)
  ) u_thresh (
    .win_code_i  (cfg_i[1:0]),
    .ov_code_i   (cfg_i[3:2]),
    .upper_mv_o  (upper_mv),
    .ov_stop_mv_o(ov_stop_mv)
  );

  for (genvar g = 0; g < N_CELL; g++) begin : g_cell
    cbs_cell_track #(.MV_W(MV_W)) u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mv_i        (cell_mv_i[g*MV_W +: MV_W]),
      .upper_mv_i  (upper_mv),
      .lower_mv_i  (LOWER),
      .ov_stop_mv_i(ov_stop_mv),
      .ov_flag_i   (ov_flag_i[g]),
      .norm_o      (norm_lat[g]),
      .ov_o        (ov_lat[g])
    );
  end

  assign normal_ok = ~bal_en_ni & ~stack_fault_i & ~dsg_fault_i & charging_i;
  assign ov_ok     = ~bal_en_ni & ~dsg_fault_i;
  assign need      = (norm_lat & {N_CELL{normal_ok}}) | (ov_lat & {N_CELL{ov_ok}});

  cbs_slot_arb #(.TBAL_CYC(TBAL_CYC)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .odd_need_i (|(need & ODD_M)),
    .even_need_i(|(need & ~ODD_M)),
    .sel_odd_o  (sel_odd)
  );

  assign bal_gate_o = meas_i ? '0 : (need & (sel_odd ? ODD_M : ~ODD_M));
  assign cbo_no     = bal_en_ni;
endmodule

// File: rtl/cbs_chk.sv
module cbs_chk #(
  parameter int N_CELL = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              meas_i,
  input logic              bal_en_ni,
  input logic [N_CELL-1:0] gate_i,
  input logic [N_CELL-1:0] need_i
);
  logic [N_CELL-1:0] om;
  always_comb begin
    om = '0;
    for (int i = 0; i < N_CELL; i += 2) om[i] = 1'b1;
  end

  logic odd_n, even_n;
  assign odd_n  = |(need_i & om);
  assign even_n = |(need_i & ~om);

  AST_NO_MIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|(gate_i & om)) && (|(gate_i & ~om)))); // R4
  AST_MEAS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_i |-> (gate_i == '0)); // R7
  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bal_en_ni |-> (gate_i == '0)); // R2
  AST_SINGLE_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_n && !even_n && !meas_i) |-> (gate_i == (need_i & om))); // R6
  AST_SINGLE_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (even_n && !odd_n && !meas_i) |-> (gate_i == (need_i & ~om))); // R6
endmodule

bind cell_bal_sched cbs_chk #(.N_CELL(N_CELL)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .meas_i   (meas_i),
  .bal_en_ni(bal_en_ni),
  .gate_i   (bal_gate_o),
  .need_i   (need)
);

// File: tb/cell_bal_sched_test.sv
module cell_bal_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 5;
  localparam int MVW  = 13;
  localparam int TBAL = 4;
  localparam int START = 3800, STEP = 50, VOV = 4300, HYS = 100;

  logic           clk = 0, rst_n = 0;
  logic [N*MVW-1:0] cell_mv;
  logic [N-1:0]   ov_flag = '0;
  logic           en_n = 1, sfault = 0, dfault = 0, chg = 0, meas = 0;
  logic [3:0]     cfg = '0;
  logic [N-1:0]   gate;
  logic           cbo_n;
  int checks = 0, errors = 0;

  cell_bal_sched #(.TBAL_CYC(TBAL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cell_mv_i(cell_mv), .ov_flag_i(ov_flag),
    .bal_en_ni(en_n), .stack_fault_i(sfault), .dsg_fault_i(dfault),
    .charging_i(chg), .meas_i(meas), .cfg_i(cfg),
    .bal_gate_o(gate), .cbo_no(cbo_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_mv(input int idx, input int mv);
    cell_mv[idx*MVW +: MVW] = MVW'(mv);
  endtask

  task automatic all_mv(input int mv);
    for (int i = 0; i < N; i++) set_mv(i, mv);
  endtask

  // one edge, then inputs may change; sample one unit later
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; #(CLK_PERIOD); @(negedge clk); rst_n = 1; #1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    all_mv(3000);
    do_reset();
    chk("R1 reset gates", gate, '0);
    chk("R10 cascade high", {4'b0, cbo_n}, 5'b1);
    en_n = 0; settle();
    chk("R10 cascade low", {4'b0, cbo_n}, 5'b0);
    chg = 1;

    // R3 threshold sweep on cell 1 for every gap code
    for (int code = 0; code < 4; code++) begin
      int up;
      up = START + (code + 1) * STEP;
      cfg = 4'(code);
      set_mv(0, up);      step(); chk("R3 at upper stays off", gate, 5'b00000);
      set_mv(0, up + 1);  step(); chk("R3 above upper on", gate, 5'b00001);
      set_mv(0, START+1); step(); chk("R3 inside window held", gate, 5'b00001);
      set_mv(0, START);   step(); chk("R3 at start released", gate, 5'b00000);
    end

    // R6 each cell alone is served immediately
    cfg = 4'd0;
    for (int i = 0; i < N; i++) begin
      set_mv(i, 4000); step(); chk("R6 single cell on", gate, 5'(1 << i));
      set_mv(i, 3000); step(); chk("R6 single cell off", gate, 5'b0);
    end

    // R2 permission gating, R7 measurement blanking
    set_mv(2, 4000); step(); chk("R2 baseline", gate, 5'b00100);
    en_n = 1;   settle(); chk("R2 enable off", gate, 5'b0);
    en_n = 0; sfault = 1; settle(); chk("R2 stack fault", gate, 5'b0);
    sfault = 0; dfault = 1; settle(); chk("R2 dsg fault", gate, 5'b0);
    dfault = 0; chg = 0; settle(); chk("R2 not charging", gate, 5'b0);
    chg = 1; meas = 1; settle(); chk("R7 meas blanks", gate, 5'b0);
    meas = 0; settle(); chk("R7 meas release", gate, 5'b00100);

    // R1/R5 alternation after fresh reset: odd {1,3}, even {2}
    all_mv(3000);
    do_reset();
    set_mv(0, 4000); set_mv(2, 4000); set_mv(1, 4000);
    step();
    for (int k = 0; k < 4*TBAL; k++) begin
      logic [N-1:0] e;
      e = ((k / TBAL) % 2 == 0) ? 5'b00101 : 5'b00010;
      chk((k < TBAL) ? "R1 odd slot first" : "R5 slot alternation", gate, e);
      chk("R4 no odd/even mix",
          {4'b0, (|(gate & 5'b10101)) && (|(gate & 5'b01010))}, 5'b0);
      step();
    end
    meas = 1; settle(); chk("R7 meas during alternation", gate, 5'b0);
    meas = 0;

    // R8/R9 over-voltage rule on cell 4 (even)
    all_mv(3000);
    do_reset();
    chg = 0; sfault = 1; cfg = 4'b0000;   // stop = max(4250,4200)=4250
    set_mv(3, 4400); ov_flag[3] = 1; step();
    chk("R8 ov ignores charge/stack fault", gate, 5'b01000);
    ov_flag[3] = 0;
    dfault = 1; settle(); chk("R8 dsg fault blocks ov", gate, 5'b0);
    dfault = 0; en_n = 1; settle(); chk("R8 enable blocks ov", gate, 5'b0);
    en_n = 0;
    set_mv(3, 4250); step(); chk("R9 code0 at stop held", gate, 5'b01000);
    set_mv(3, 4249); step(); chk("R9 code0 below stop off", gate, 5'b0);
    cfg = 4'b1100;                          // stop = max(4100,4200)=4200
    set_mv(3, 4400); ov_flag[3] = 1; step(); ov_flag[3] = 0;
    set_mv(3, 4200); step(); chk("R9 code3 at hys level held", gate, 5'b01000);
    set_mv(3, 4199); step(); chk("R9 code3 below hys off", gate, 5'b0);
    cfg = 4'b0100;                          // stop = max(4200,4200)=4200
    set_mv(3, 4400); ov_flag[3] = 1; step(); ov_flag[3] = 0;
    set_mv(3, 4200); step(); chk("R9 code1 at stop held", gate, 5'b01000);
    set_mv(3, 4199); step(); chk("R9 code1 below stop off", gate, 5'b0);
    en_n = 1; settle(); chk("R10 cascade follows", {4'b0, cbo_n}, 5'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule